// File: doc/BRIEF.md
# Converter Result Byte Registers with Read-Order Lock

This block sits between a 10-bit successive-approximation converter core and an 8-bit register read/write bus. When the core pulses its done strobe with a finished 10-bit sample, the block stores the sample as two data bytes. The layout is either right-adjusted or left-adjusted, and a control bit picks which one. In left-adjusted form, software that only needs 8 bits can read the high byte alone.

Software that wants the full sample reads the low byte first and the high byte second. Reading the low byte freezes both data bytes against converter writes, and reading the high byte releases them. This keeps the two halves from two different conversions apart. A sample that arrives while the bytes are frozen is dropped. Its completion is still recorded in a sticky flag. Software clears the flag by writing a one to it, and the flag drives an interrupt line that an enable bit gates.

The bus uses a 2-bit address. Address 0 is the low data byte, address 1 is the high data byte, and address 2 is the control byte, laid out as bit 0 left-adjust, bit 1 interrupt enable and bit 2 completion flag. Address 3 reads zero. Reads are combinational from the stored state. Their side effects take place at the clock edge on which `busRead` is high.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, the low byte, high byte and control byte all read 0x00, the lock is released and `irqOut` is low.
- R2: With control bit 0 clear when a sample is captured, the low byte holds sample bits 7..0, high byte bits 1..0 hold sample bits 9..8, and high byte bits 7..2 are zero.
- R3: With control bit 0 set when a sample is captured, the high byte holds sample bits 9..2, low byte bits 7..6 hold sample bits 1..0, and low byte bits 5..0 are zero.
- R4: The layout bit is applied only when a sample is captured. Changing it leaves already stored data bytes untouched, and no data byte changes in a cycle without a capture.
- R5: A read of address 0 sets the lock. While the lock is set, a completed sample changes neither data byte.
- R6: A read of address 1 releases the lock, so the next completed sample is captured. Reads of address 1 alone never set the lock.
- R7: A sample completing in the same cycle as a read of address 0 is dropped. A sample completing in the same cycle as the releasing read of address 1 is captured, and that read returns the older high byte.
- R8: The completion flag (control bit 2) sets on every completed sample, including a dropped one.
- R9: Writing a one to control bit 2 clears the flag, and writing a zero there leaves it unchanged. A completion in the same cycle as the clearing write leaves the flag set.
- R10: `irqOut` is high exactly when the completion flag and the interrupt enable (control bit 1) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle strobe from the converter core: a sample is finished |
| convResult | input | 10 | Finished sample, valid while convDone is high |
| busAddr | input | 2 | Register address: 0 low data, 1 high data, 2 control |
| busRead | input | 1 | Read strobe; the side effects take place at the clock edge |
| busWrite | input | 1 | Write strobe; only address 2 is writable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| irqOut | output | 1 | Completion interrupt request |

## Verification
On every cycle, the assertions check the lock state machine. A low-byte read sets the lock and a high-byte read releases it. They also check that the data bytes stay frozen under the lock or when no capture happens, and that the same-cycle low-read case drops the sample. They further check that every completion leaves the flag set, and that the zero-filled bits of each layout stay zero after a capture. The actual bit placement of every possible sample in both layouts is shown only by the bench's sweep. The same holds for the data seen through the bus after a dropped sample, the write-one-to-clear ordering and the interrupt gating.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;

  // Register addresses on the byte bus
  localparam int ADDR_LO   = 0;
  localparam int ADDR_HI   = 1;
  localparam int ADDR_CTRL = 2;

  // Control byte bit positions (software visible)
  localparam int CTRL_LEFT_BIT = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_FLAG_BIT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // write the presented sample into the data bytes
    logic leftAdj;   // layout to use for that write
  } dpStrobes_t;

endpackage

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
  import adc_result_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output dpStrobes_t        strobes,
  output logic              lockQ,
  output logic              flagQ,
  output logic              leftAdjQ,
  output logic              irqEnQ,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] LoAddr   = ADDR_W'(ADDR_LO);
  localparam logic [ADDR_W-1:0] HiAddr   = ADDR_W'(ADDR_HI);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(ADDR_CTRL);

  logic loRead;
  logic hiRead;
  logic ctrlWrite;
  logic flagClear;

  assign loRead    = busRead  && (busAddr == LoAddr);
  assign hiRead    = busRead  && (busAddr == HiAddr);
  assign ctrlWrite = busWrite && (busAddr == CtrlAddr);
  assign flagClear = ctrlWrite && busWdata[CTRL_FLAG_BIT];

  // Capture when not frozen; a low read in this cycle freezes immediately,
  // a high read in this cycle releases immediately.
  always_comb begin
    strobes.capture = convDone && !loRead && (!lockQ || hiRead);
    strobes.leftAdj = leftAdjQ;
  end

  // Read-order lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= 1'b0;
    end else if (loRead) begin
      lockQ <= 1'b1;
    end else if (hiRead) begin
      lockQ <= 1'b0;
    end
  end

  // Completion flag: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (convDone) begin
      flagQ <= 1'b1;
    end else if (flagClear) begin
      flagQ <= 1'b0;
    end
  end

  // Software control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftAdjQ <= 1'b0;
      irqEnQ   <= 1'b0;
    end else if (ctrlWrite) begin
      leftAdjQ <= busWdata[CTRL_LEFT_BIT];
      irqEnQ   <= busWdata[CTRL_IRQ_BIT];
    end
  end

  always_comb begin
    ctrlByte                = '0;
    ctrlByte[CTRL_LEFT_BIT] = leftAdjQ;
    ctrlByte[CTRL_IRQ_BIT]  = irqEnQ;
    ctrlByte[CTRL_FLAG_BIT] = flagQ;
  end

  assign irqOut = flagQ && irqEnQ;

endmodule

// File: rtl/adc_result_dp.sv
module adc_result_dp
  import adc_result_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RES_W-1:0]  convResult,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] ctrlByte,
  output logic [DATA_W-1:0] loData,
  output logic [DATA_W-1:0] hiData,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PairW = 2 * DATA_W;
  localparam int Shift = PairW - RES_W;

  logic [PairW-1:0] rightFmt;
  logic [PairW-1:0] leftFmt;
  logic [PairW-1:0] chosenFmt;

  always_comb begin
    rightFmt  = PairW'(convResult);
    leftFmt   = rightFmt << Shift;
    chosenFmt = strobes.leftAdj ? leftFmt : rightFmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loData <= '0;
      hiData <= '0;
    end else if (strobes.capture) begin
      loData <= chosenFmt[DATA_W-1:0];
      hiData <= chosenFmt[PairW-1:DATA_W];
    end
  end

  always_comb begin
    if (busAddr == ADDR_W'(ADDR_LO)) begin
      busRdata = loData;
    end else if (busAddr == ADDR_W'(ADDR_HI)) begin
      busRdata = hiData;
    end else if (busAddr == ADDR_W'(ADDR_CTRL)) begin
      busRdata = ctrlByte;
    end else begin
      busRdata = '0;
    end
  end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_result_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  dpStrobes_t        strobes;
  logic              lockQ;
  logic              flagQ;
  logic              leftAdjQ;
  logic              irqEnQ;
  logic [DATA_W-1:0] ctrlByte;
  logic [DATA_W-1:0] loData;
  logic [DATA_W-1:0] hiData;

  adc_result_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .convDone (convDone),
    .busAddr  (busAddr),
    .busRead  (busRead),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .strobes  (strobes),
    .lockQ    (lockQ),
    .flagQ    (flagQ),
    .leftAdjQ (leftAdjQ),
    .irqEnQ   (irqEnQ),
    .ctrlByte (ctrlByte),
    .irqOut   (irqOut)
  );

  adc_result_dp #(.RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .convResult (convResult),
    .strobes    (strobes),
    .busAddr    (busAddr),
    .ctrlByte   (ctrlByte),
    .loData     (loData),
    .hiData     (hiData),
    .busRdata   (busRdata)
  );

endmodule

// File: rtl/adc_result_checker.sv
module adc_result_checker #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              convDone,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              lockQ,
  input logic              leftAdjQ,
  input logic              flagQ,
  input logic              captureEn,
  input logic [DATA_W-1:0] loData,
  input logic [DATA_W-1:0] hiData
);

  localparam int HiTop  = RES_W - DATA_W;
  localparam int LoFill = 2 * DATA_W - RES_W;

  logic loRead;
  logic hiRead;
  assign loRead = busRead && (busAddr == ADDR_W'(0));
  assign hiRead = busRead && (busAddr == ADDR_W'(1));

  assert_lock_on_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    loRead |=> lockQ);

  assert_release_on_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    hiRead |=> !lockQ);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && convDone && !hiRead) |=> ($stable(loData) && $stable(hiData)));

  assert_same_cycle_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && loRead) |=> ($stable(loData) && $stable(hiData)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !captureEn |=> ($stable(loData) && $stable(hiData)));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> flagQ);

  assert_right_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && !leftAdjQ) |=> (hiData[DATA_W-1:HiTop] == '0));

  assert_left_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && leftAdjQ) |=> (loData[LoFill-1:0] == '0));

endmodule

bind adc_result_regs adc_result_checker #(
  .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .convDone  (convDone),
  .busAddr   (busAddr),
  .busRead   (busRead),
  .lockQ     (lockQ),
  .leftAdjQ  (leftAdjQ),
  .flagQ     (flagQ),
  .captureEn (strobes.capture),
  .loData    (loData),
  .hiData    (hiData)
);

// File: tb/test_adc_result_regs.sv
`timescale 1ns/1ps
module test_adc_result_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convDone = 1'b0;
  logic [9:0] convResult = '0;
  logic [1:0] busAddr = '0;
  logic       busRead = 1'b0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_result_regs i_adc_result_regs (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convResult(convResult),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic doConv(input logic [9:0] v);
    convDone = 1'b1; convResult = v;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic doReadConv(input logic [1:0] a, input logic [9:0] v, output logic [7:0] d);
    busAddr = a; busRead = 1'b1; convDone = 1'b1; convResult = v;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0; convDone = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] w, input logic withConv, input logic [9:0] v);
    busAddr = 2'd2; busWrite = 1'b1; busWdata = w;
    convDone = withConv; convResult = v;
    @(negedge clk);
    busWrite = 1'b0; convDone = 1'b0;
  endtask

  function automatic logic [15:0] expectPair(input logic [9:0] v, input logic left);
    // returns {high, low}
    if (left) return {v[9:2], v[1:0], 6'b0};
    return {6'b0, v[9:8], v[7:0]};
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] lo, hi, cb;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'b0, irqOut}, 16'h0);
    doRead(2'd2, cb); check("R1 ctrl", {8'h0, cb}, 16'h0);
    doRead(2'd0, lo); check("R1 low", {8'h0, lo}, 16'h0);
    doRead(2'd1, hi); check("R1 high", {8'h0, hi}, 16'h0);
    doRead(2'd3, cb); check("R1 unused addr", {8'h0, cb}, 16'h0);

    // R2/R3 sweep over every sample in both layouts
    for (int mode = 0; mode < 2; mode++) begin
      doWrite(8'(mode), 1'b0, '0);
      for (int v = 0; v < 1024; v++) begin
        doConv(10'(v));
        e = expectPair(10'(v), mode[0]);
        doRead(2'd0, lo);
        doRead(2'd1, hi);
        check(mode ? "R3 left layout" : "R2 right layout", {hi, lo}, e);
      end
    end

    // R4 layout change does not rearrange stored data
    doWrite(8'h00, 1'b0, '0);
    doConv(10'h2A5);
    doWrite(8'h01, 1'b0, '0);
    doRead(2'd0, lo); doRead(2'd1, hi);
    check("R4 no rearrange", {hi, lo}, 16'h02A5);
    doConv(10'h2A5);
    doRead(2'd0, lo); doRead(2'd1, hi);
    check("R4 next capture left", {hi, lo}, expectPair(10'h2A5, 1'b1));

    // R5 lock on low read drops a completion; R8 flag still sets
    doWrite(8'h04, 1'b0, '0);           // right layout, clear flag
    doConv(10'h155);
    doWrite(8'h04, 1'b0, '0);           // clear flag again
    doRead(2'd0, lo); check("R5 low", {8'h0, lo}, 16'h0055);
    doConv(10'h3AA);
    doRead(2'd2, cb); check("R8 flag on dropped", {15'b0, cb[2]}, 16'h1);
    doRead(2'd1, hi); check("R5 high frozen", {8'h0, hi}, 16'h0001);
    doRead(2'd0, lo); check("R5 low not overwritten", {8'h0, lo}, 16'h0055);
    doRead(2'd1, hi);

    // R6 high-only reads never lock
    doWrite(8'h01, 1'b0, '0);
    doConv(10'h3C4);
    doRead(2'd1, hi); check("R6 high-only first", {8'h0, hi}, 16'h00F1);
    doConv(10'h11B);
    doRead(2'd1, hi); check("R6 high-only second", {8'h0, hi}, 16'h0046);
    doConv(10'h200);
    doRead(2'd0, lo); doRead(2'd1, hi);
    check("R6 released capture", {hi, lo}, expectPair(10'h200, 1'b1));

    // R7 same-cycle cases
    doWrite(8'h00, 1'b0, '0);
    doConv(10'h0F0);
    doReadConv(2'd0, 10'h30F, lo); check("R7 low read data", {8'h0, lo}, 16'h00F0);
    doReadConv(2'd1, 10'h2CC, hi); check("R7 releasing read old high", {8'h0, hi}, 16'h0000);
    doRead(2'd0, lo); doRead(2'd1, hi);
    check("R7 capture at release", {hi, lo}, 16'h02CC);

    // R9 write-one-to-clear
    doConv(10'h001);
    doWrite(8'h00, 1'b0, '0);
    doRead(2'd2, cb); check("R9 zero write keeps flag", {15'b0, cb[2]}, 16'h1);
    doWrite(8'h04, 1'b0, '0);
    doRead(2'd2, cb); check("R9 one clears flag", {15'b0, cb[2]}, 16'h0);
    doWrite(8'h04, 1'b1, 10'h002);
    doRead(2'd2, cb); check("R9 set wins", {15'b0, cb[2]}, 16'h1);
    doRead(2'd0, lo); doRead(2'd1, hi);

    // R10 interrupt gating
    doWrite(8'h00, 1'b0, '0);
    #1 check("R10 disabled", {15'b0, irqOut}, 16'h0);
    doWrite(8'h02, 1'b0, '0);
    #1 check("R10 flag and enable", {15'b0, irqOut}, 16'h1);
    doRead(2'd2, cb); check("R10 ctrl byte", {8'h0, cb}, 16'h0006);
    doWrite(8'h06, 1'b0, '0);
    #1 check("R10 flag cleared", {15'b0, irqOut}, 16'h0);
    doConv(10'h0AA);
    #1 check("R10 new completion", {15'b0, irqOut}, 16'h1);

    summary();
  end

endmodule